// File: doc/BRIEF.md
# Light-Sensor Register Slave on I2C

This block is the serial front end of an ambient-light measurement peripheral. It watches the two I2C wires, which it samples in a fast system clock domain, and answers only to its own fixed 7-bit bus address. Through that address a host reaches a small register file that is not contiguous. Two command bytes set the operating mode, the conversion resolution and the full-scale range, and these fields are driven straight to the measurement logic. Two read-only bytes hold the latest 16-bit conversion result, which the measurement logic loads through a strobe. One identification byte carries a fixed code and a brownout flag that is set at power-up.

A write transfer places the register pointer and may then write one or more data bytes. After each data byte the pointer steps through the mapped addresses 0x00, 0x01, 0x02, 0x03, 0x0F and then returns to 0x00. A read uses the combined format. A write-addressed transfer sets the pointer, a repeated START follows, and then the read-addressed transfer streams bytes in the same order for as long as the host acknowledges them. If a STOP arrives before a data byte and its acknowledge clock are complete, that byte is dropped.

Top module: `lux_i2c_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1000100. Bit 0 selects read (1) or write (0). After any other address, SDA stays released for the rest of the transfer and no register or pointer changes.
- R2: Bytes travel MSB first. The slave acknowledges by pulling SDA low for the ninth SCL clock of the address byte, the register-address byte and every written data byte. Its SDA enable changes only while the synchronized SCL is low.
- R3: A byte write (START, 0x88, register address, data, STOP) stores the data at that address. The store happens when the data byte's acknowledge clock ends.
- R4: In a burst write, each further data byte is acknowledged and goes to the next address in the order 0x00, 0x01, 0x02, 0x03, 0x0F, 0x00. An unmapped address below 0x0F steps by one.
- R5: A combined read (write-addressed pointer set, repeated START, 0x89) returns the byte at the pointer. The pointer advances in the R4 order after each byte the host acknowledges, and a NACK ends the stream.
- R6: A STOP that arrives in the middle of a data byte ends the transfer. No register changes, and SDA is released one clock after the STOP is seen.
- R7: After reset, registers 0x00 to 0x03 read 0x00, register 0x0F reads 0xA8, and all field outputs are 0.
- R8: Register 0x00 bits [7:5] drive mode_o and its other bits read 0. Register 0x01 bits [3:2] drive adc_res_o and bits [1:0] drive lux_range_o, and its bits [7:4] read 0.
- R9: A pulse on result_ld_i stores result_i. Bits [7:0] read at 0x02 and bits [15:8] read at 0x03, and host writes to these two addresses change nothing.
- R10: Register 0x0F reads {brownout, 0, 101, 000}. Writing 0 to bit 7 clears the brownout flag. Writing 1 leaves it unchanged, and only reset sets it.
- R11: Writes to unmapped addresses are acknowledged and ignored, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open drain) |
| result_i | input | 16 | Conversion result from the measurement logic |
| result_ld_i | input | 1 | Load strobe for result_i |
| mode_o | output | 3 | Operating mode field |
| adc_res_o | output | 2 | Resolution field |
| lux_range_o | output | 2 | Full-scale range field |
| brownout_o | output | 1 | Brownout flag |

## Verification
The bench tries burst reads that start at 0x00, which walk the whole sparse order including the 0x0F to 0x00 wrap, and burst writes that start at 0x01, which cross the read-only bytes, the ID byte and the wrap. A wrong device address, a STOP in the middle of a data byte, a STOP right after the pointer byte, writes of 1 and of 0 to the brownout bit, and unmapped-address accesses each show a different ignore path. Loaded results with distinct high and low bytes show the byte order and that read-only bytes cannot be written.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] A_CMD0 = 8'h00;
  localparam logic [AW-1:0] A_CMD1 = 8'h01;
  localparam logic [AW-1:0] A_RLO  = 8'h02;
  localparam logic [AW-1:0] A_RHI  = 8'h03;
  localparam logic [AW-1:0] A_IDST = 8'h0F;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_REG, S_WDAT, S_RDAT, S_MACK
  } ser_state_t;

  // sparse pointer walk: last result byte jumps to ID, ID wraps to first
  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    if (p == A_RHI)       return A_IDST;
    else if (p == A_IDST) return A_CMD0;
    else                  return p + 1'b1;
  endfunction
endpackage

// File: rtl/lux_i2c_sync.sv
module lux_i2c_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int unsigned NLINES = 2;
  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic scl_q, sda_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/lux_i2c_serial.sv
module lux_i2c_serial
  import lux_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          ptr_adv,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_oe
);
  localparam int unsigned CW = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS = CW'(DW);

  ser_state_t    st;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] tx;
  logic          in_ack;
  logic          mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      tx      <= '0;
      in_ack  <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      ptr_adv <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      ptr_adv <= 1'b0;
      if (stop_evt) begin
        st     <= S_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        st     <= S_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_DEV, S_REG, S_WDAT: begin
            if (scl_rise && !in_ack) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && in_ack) begin
              in_ack <= 1'b0;
              sda_oe <= 1'b0;
              bitcnt <= '0;
              if (st == S_DEV) begin
                if (shreg[0]) begin
                  st     <= S_RDAT;
                  tx     <= rd_data << 1;
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  st <= S_REG;
                end
              end else if (st == S_REG) begin
                ptr <= shreg;
                st  <= S_WDAT;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= shreg;
                ptr     <= ptr_next(ptr);
                ptr_adv <= 1'b1;
              end
            end else if (scl_fall && bitcnt == BITS) begin
              if (st == S_DEV && shreg[DW-1:1] != DEV_ADDR) begin
                st <= S_IDLE;
              end else begin
                in_ack <= 1'b1;
                sda_oe <= 1'b1;
              end
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == BITS) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~tx[DW-1];
                tx     <= tx << 1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
              if (!sda_s) begin
                ptr     <= ptr_next(ptr);
                ptr_adv <= 1'b1;
              end
            end else if (scl_fall) begin
              if (mack) begin
                st     <= S_RDAT;
                bitcnt <= '0;
                tx     <= rd_data << 1;
                sda_oe <= ~rd_data[DW-1];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lux_i2c_regs.sv
module lux_i2c_regs
  import lux_i2c_pkg::*;
#(
  parameter int unsigned RES_W   = 2 * DW,
  parameter logic [2:0]  ID_CODE = 3'b101
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [RES_W-1:0] result_i,
  input  logic             result_ld_i,
  output logic [RES_W-1:0] result_q,
  output logic [2:0]       mode_o,
  output logic [1:0]       adc_res_o,
  output logic [1:0]       lux_range_o,
  output logic             bout
);
  localparam logic [DW-1:0] MASK0 = 8'hE0;
  localparam logic [DW-1:0] MASK1 = 8'h0F;

  logic [DW-1:0] cmd0, cmd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd0     <= '0;
      cmd1     <= '0;
      result_q <= '0;
      bout     <= 1'b1;
    end else begin
      if (result_ld_i) result_q <= result_i;
      if (wr_en) begin
        case (wr_addr)
          A_CMD0:  cmd0 <= wr_data & MASK0;
          A_CMD1:  cmd1 <= wr_data & MASK1;
          A_IDST:  if (!wr_data[DW-1]) bout <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CMD0:  rd_data = cmd0;
      A_CMD1:  rd_data = cmd1;
      A_RLO:   rd_data = result_q[DW-1:0];
      A_RHI:   rd_data = result_q[RES_W-1:DW];
      A_IDST:  rd_data = {bout, 1'b0, ID_CODE, 3'b000};
      default: rd_data = '0;
    endcase
  end

  assign mode_o      = cmd0[7:5];
  assign adc_res_o   = cmd1[3:2];
  assign lux_range_o = cmd1[1:0];
endmodule

// File: rtl/lux_i2c_regslave.sv
module lux_i2c_regslave
  import lux_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'b1000100,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [2:0]  ID_CODE     = 3'b101
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [15:0] result_i,
  input  logic        result_ld_i,
  output logic [2:0]  mode_o,
  output logic [1:0]  adc_res_o,
  output logic [1:0]  lux_range_o,
  output logic        brownout_o
);
  localparam int unsigned RES_W = 2 * DW;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic ptr_adv, wr_en, sda_oe, bout;
  logic [RES_W-1:0] result_q;

  lux_i2c_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  lux_i2c_serial #(.DEV_ADDR(DEV_ADDR)) i_serial (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .ptr(ptr), .ptr_adv(ptr_adv), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  lux_i2c_regs #(.RES_W(RES_W), .ID_CODE(ID_CODE)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .result_i(result_i), .result_ld_i(result_ld_i), .result_q(result_q),
    .mode_o(mode_o), .adc_res_o(adc_res_o), .lux_range_o(lux_range_o),
    .bout(bout)
  );

  assign sda_oe_o   = sda_oe;
  assign brownout_o = bout;
endmodule

// File: rtl/lux_i2c_regslave_chk.sv
module lux_i2c_regslave_chk (
  input logic        clk,
  input logic        rst,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        stop_evt,
  input logic [7:0]  ptr,
  input logic        ptr_adv,
  input logic        bout,
  input logic        result_ld_i,
  input logic [15:0] result_i,
  input logic [15:0] result_q
);
  a_r2_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  a_r6_stop_release: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  a_r4_skip_to_id: assert property (@(posedge clk) disable iff (rst)
    (ptr_adv && $past(ptr) == 8'h03) |-> ptr == 8'h0F);

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (ptr_adv && $past(ptr) == 8'h0F) |-> ptr == 8'h00);

  a_r9_result_load: assert property (@(posedge clk) disable iff (rst)
    result_ld_i |=> result_q == $past(result_i));

  a_r10_bout_sticky_clear: assert property (@(posedge clk) disable iff (rst)
    !$past(bout) |-> !bout);

  a_r7_bout_reset: assert property (@(posedge clk)
    $past(rst) |-> bout);
endmodule

bind lux_i2c_regslave lux_i2c_regslave_chk i_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .stop_evt(stop_evt),
  .ptr(ptr), .ptr_adv(ptr_adv), .bout(bout), .result_ld_i(result_ld_i),
  .result_i(result_i), .result_q(result_q)
);

// File: tb/test_lux_i2c_regslave.sv
`timescale 1ns/1ps
module test_lux_i2c_regslave;
  localparam int HT = 20;
  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [15:0] result_i = '0;
  logic result_ld_i = 0;
  logic [2:0] mode_o;
  logic [1:0] adc_res_o, lux_range_o;
  logic brownout_o;
  wire  sda_w = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  lux_i2c_regslave i_lux_i2c_regslave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_w), .sda_oe_o(sda_oe),
    .result_i(result_i), .result_ld_i(result_ld_i), .mode_o(mode_o),
    .adc_res_o(adc_res_o), .lux_range_o(lux_range_o), .brownout_o(brownout_o)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, cmp_bad = 0;
  bit idle_cmp = 0;
  bit [2:0] m_mode; bit [3:0] m_cmd1; bit [15:0] m_res; bit m_bout;
  bit [7:0] wrq[$];
  bit [7:0] rdq[$];
  int acks;

  function automatic bit [7:0] m_next(bit [7:0] a);
    if (a == 8'h03) return 8'h0F;
    if (a == 8'h0F) return 8'h00;
    return a + 8'd1;
  endfunction
  function automatic bit [7:0] m_read(bit [7:0] a);
    case (a)
      8'h00: return {m_mode, 5'b0};
      8'h01: return {4'b0, m_cmd1};
      8'h02: return m_res[7:0];
      8'h03: return m_res[15:8];
      8'h0F: return {m_bout, 1'b0, 3'b101, 3'b000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference compare of the field outputs on every clock while the bus is idle
  always @(negedge clk) begin
    cyc++;
    if (idle_cmp && ({mode_o, adc_res_o, lux_range_o, brownout_o, sda_oe} !=
        {m_mode, m_cmd1, m_bout, 1'b0})) cmp_bad++;
    if (cyc == 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick(int n); repeat (n) @(posedge clk); #1; endtask
  task automatic send_bit(bit b);
    sda_m = b; tick(HT); scl_m = 1; tick(HT); scl_m = 0; tick(2);
  endtask
  task automatic get_bit(output bit b);
    sda_m = 1; tick(HT); scl_m = 1; tick(HT/2); b = sda_w; tick(HT/2); scl_m = 0; tick(2);
  endtask
  task automatic do_start;
    idle_cmp = 0;
    sda_m = 1; tick(HT); scl_m = 1; tick(HT); sda_m = 0; tick(HT); scl_m = 0; tick(2);
  endtask
  task automatic do_stop;
    sda_m = 0; tick(HT); scl_m = 1; tick(HT); sda_m = 1; tick(HT);
    tick(6); idle_cmp = 1;
  endtask
  task automatic put_byte(bit [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    if (!b) acks++;
  endtask
  task automatic get_byte(output bit [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    send_bit(!ack);
  endtask

  // write transfer of all bytes in wrq; model follows the requirements
  task automatic bus_write(bit [7:0] dev, bit [7:0] ra);
    bit [7:0] p;
    acks = 0;
    do_start; put_byte(dev); put_byte(ra);
    foreach (wrq[i]) put_byte(wrq[i]);
    do_stop;
    if (dev == 8'h88) begin
      p = ra;
      foreach (wrq[i]) begin
        if (p == 8'h00) m_mode = wrq[i][7:5];
        if (p == 8'h01) m_cmd1 = wrq[i][3:0];
        if (p == 8'h0F && !wrq[i][7]) m_bout = 0;
        p = m_next(p);
      end
    end
  endtask

  task automatic bus_read(bit [7:0] ra, int n, string req);
    bit [7:0] d, p;
    rdq.delete(); acks = 0;
    do_start; put_byte(8'h88); put_byte(ra);
    do_start; put_byte(8'h89);
    for (int i = 0; i < n; i++) begin get_byte(d, i != n-1); rdq.push_back(d); end
    do_stop;
    chk({req, " acks"}, acks, 3);
    p = ra;
    foreach (rdq[i]) begin chk(req, rdq[i], m_read(p)); p = m_next(p); end
  endtask

  initial begin
    m_mode = 0; m_cmd1 = 0; m_res = 0; m_bout = 1;
    tick(5); rst = 0; tick(5);
    // R7 reset state at the ports
    chk("R7 fields", {mode_o, adc_res_o, lux_range_o}, 0);
    chk("R7 brownout", brownout_o, 1);
    chk("R7 sda_oe", sda_oe, 0);
    idle_cmp = 1;
    // R5 R4 R7 R10: walk whole sparse order with wrap, 0xA8 at 0x0F
    bus_read(8'h00, 6, "R5 R7 burst read after reset");
    // R1: wrong address gets NACK and writes nothing
    wrq = '{8'hFF}; acks = 0;
    do_start; put_byte(8'h8A); put_byte(8'h00); put_byte(8'hFF); do_stop;
    chk("R1 nack on mismatch", acks, 0);
    chk("R1 no write", mode_o, 0);
    // R3 R8 byte write, reserved bits read 0
    wrq = '{8'hFF}; bus_write(8'h88, 8'h00);
    chk("R3 byte write acks", acks, 3);
    chk("R8 mode_o", mode_o, 7);
    bus_read(8'h00, 1, "R8 cmd0 readback");
    // R4 burst write across read-only, ID and wrap; R9 R10
    wrq = '{8'h0F, 8'h11, 8'h22, 8'h00, 8'h40}; bus_write(8'h88, 8'h01);
    chk("R4 burst acks", acks, 7);
    chk("R4 wrap to cmd0", mode_o, 2);
    chk("R8 adc_res_o", adc_res_o, 3);
    chk("R8 lux_range_o", lux_range_o, 3);
    chk("R10 cleared", brownout_o, 0);
    bus_read(8'h01, 3, "R9 read-only untouched");
    bus_read(8'h0F, 1, "R10 id after clear");
    // R10 writing 1 does not set
    wrq = '{8'h80}; bus_write(8'h88, 8'h0F);
    chk("R10 write one ignored", brownout_o, 0);
    // R9 load and byte order
    @(posedge clk); #1 result_i = 16'hBEEF; result_ld_i = 1;
    @(posedge clk); #1 result_ld_i = 0; m_res = 16'hBEEF;
    bus_read(8'h02, 2, "R9 result bytes");
    wrq = '{8'h12, 8'h34}; bus_write(8'h88, 8'h02);
    bus_read(8'h02, 2, "R9 host write ignored");
    // R11 unmapped
    wrq = '{8'h55}; bus_write(8'h88, 8'h07);
    chk("R11 unmapped ack", acks, 3);
    bus_read(8'h07, 1, "R11 unmapped reads zero");
    // R6 stop mid data byte
    acks = 0;
    do_start; put_byte(8'h88); put_byte(8'h00);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    do_stop;
    chk("R6 mid-byte stop keeps mode", mode_o, 2);
    do_start; put_byte(8'h88); put_byte(8'h01); do_stop;
    chk("R6 pointer-only write", {adc_res_o, lux_range_o}, 4'hF);
    bus_read(8'h00, 2, "R6 R2 readback after aborts");
    chk("R8 continuous compare mismatches", cmp_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule